// File: doc/BRIEF.md
# Raster-to-Tile Pixel Feeder

This block turns a raster-scanned pixel stream into the 8x8 tiles that a block-based image compressor consumes. Pixels arrive one per handshake in line order. The block keeps two stripe banks, each eight lines tall and one frame wide. While one bank fills from the incoming stream, the other bank is read out tile by tile. The block also drives the row index and the column select that address the pixel array, and it holds an end-of-frame flag once the last tile has left.

The input side is a valid/ready stream. A pixel moves only on a rising edge where `pix_valid` and `pix_ready` are both high. The producer may hold `pix_valid` for any number of cycles and must keep `pix_data` stable until the transfer. The block lowers `pix_ready` when it has no space, and the producer must simply wait. The output side is the compressor's plain enable pin and has no back-pressure. Each tile is a burst of 64 pixel cycles. A fixed hold of `HOLD_CYC` cycles follows with the enable still high. Then the enable drops for a single cycle before the next tile.

Top module: `raster_tile_feeder`

## Requirements
- R1: A pixel is stored only on a rising edge where `pix_valid` and `pix_ready` are both high. `pix_ready` is low from reset until the first `frame_start`. It is also low while the bank being filled still waits to be drained, and after the last pixel of a frame. A pixel offered while `pix_ready` is low is not stored and does not move `row_idx` or `col_sel`.
- R2: `col_sel` steps by one per accepted pixel and wraps from `IMG_W-1` to 0. At that wrap `row_idx` steps by one, and `row_idx` wraps from `IMG_H-1` to 0. Before each transfer, the two outputs equal the row and column of the pixel being offered.
- R3: In the cycle after `frame_start`, `row_idx`, `col_sel`, `cmp_en` and `eof` are all 0. Any buffered stripes are discarded, and capture is armed for a new frame.
- R4: On every cycle that carries a pixel, `cmp_data` holds that pixel in bits 7:0, 15:8 and 23:16. During the hold cycles it is zero.
- R5: Tile t of stripe s covers rows 8s..8s+7 and columns 8t..8t+7. Its 64 pixels leave in row-major order, eight pixels of tile row 0 first. Tiles of a stripe leave left to right, and stripes leave top to bottom.
- R6: For each tile, `cmp_en` is high for exactly 64+`HOLD_CYC` (97) consecutive cycles, and the first 64 of them carry the pixels. Between two tiles `cmp_en` is low for exactly one cycle whenever the next tile's stripe is already complete.
- R7: `eof` rises on the edge that ends the one-cycle enable drop after the frame's final tile. It stays high until `frame_start` or reset, and `cmp_en` stays low while it is high.
- R8: Capture into one bank goes on while the other bank is being drained. When both banks hold complete stripes, `pix_ready` stays low until the draining bank is released.
- R9: After reset, `pix_ready`, `row_idx`, `col_sel`, `cmp_data`, `cmp_en` and `eof` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that restarts capture and drain for a new frame |
| pix_valid | input | 1 | Incoming pixel is valid |
| pix_data | input | PIX_W | Incoming pixel value |
| pix_ready | output | 1 | Block can store the offered pixel this cycle |
| row_idx | output | $clog2(IMG_H) | Row being scanned |
| col_sel | output | $clog2(IMG_W) | Column being scanned |
| cmp_data | output | 3*PIX_W | Pixel copied into all three byte lanes |
| cmp_en | output | 1 | Compressor enable, high through a tile burst and its hold |
| eof | output | 1 | Frame fully delivered, sticky |

## Verification
The bench uses a three-stripe frame and streams it with no idle cycles. Drain is slower than capture, so a third stripe has to stall until the first bank is released. A design that overwrote the bank still being read would send a tile whose pixels belong to the wrong rows. A second frame arrives with long idle gaps, so the drain sits idle between tiles. An off-by-one hold counter shows up as a burst that is not 97 cycles long, and a drain that idles after the drop shows up as a two-cycle gap. A restart pulse in the middle of a frame must leave the counters at zero and discard stale stripes. If it did not, the next frame would begin with old tiles or with `eof` already set.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_SEND = 2'd1,
    DR_HOLD = 2'd2,
    DR_GAP  = 2'd3
  } drain_st_e;
endpackage

// File: rtl/rtf_scan_ctr.sv
module rtf_scan_ctr #(
  parameter int MAX = 319,
  parameter int W   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         at_max
);
  assign at_max = (q == W'(MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (en)     q <= at_max ? '0 : q + 1'b1;
  end

  // R3: synchronous clear
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  // R2: step and wrap
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !at_max) |=> (q == $past(q) + 1'b1));
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && at_max) |=> (q == '0));
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/rtf_stripe_store.sv
module rtf_stripe_store #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 5120,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rtf_tile_drain.sv
module rtf_tile_drain
  import rtf_pkg::*;
#(
  parameter int IMG_W    = 320,
  parameter int IMG_H    = 240,
  parameter int TILE     = 8,
  parameter int HOLD_CYC = 33,
  localparam int TB      = $clog2(TILE),
  localparam int BPS     = IMG_W / TILE,
  localparam int SPF     = IMG_H / TILE,
  localparam int BANK_SZ = TILE * IMG_W,
  localparam int AW      = $clog2(2 * BANK_SZ),
  localparam int BCW     = (BPS > 1) ? $clog2(BPS) : 1,
  localparam int SFW     = (SPF > 1) ? $clog2(SPF) : 1,
  localparam int HW      = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1,
  localparam int RUNW    = $clog2(TILE * TILE + HOLD_CYC + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [1:0]    full,
  output logic          rbank,
  output logic          release_bank,
  output logic [AW-1:0] rd_addr,
  output logic          send,
  output logic          cmp_en,
  output logic          eof
);
  drain_st_e      st;
  logic [TB-1:0]  tcol, trow;
  logic [BCW-1:0] bc;
  logic [SFW-1:0] stripe;
  logic [HW-1:0]  hcnt;

  wire last_tile_col = (bc == BCW'(BPS - 1));

  assign send         = (st == DR_SEND);
  assign cmp_en       = (st == DR_SEND) || (st == DR_HOLD);
  assign release_bank = (st == DR_GAP) && last_tile_col;
  assign rd_addr = AW'((int'(rbank) * BANK_SZ) + (int'(trow) * IMG_W)
                     + (int'(bc) * TILE) + int'(tcol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= DR_IDLE; tcol <= '0; trow <= '0; bc <= '0;
      stripe <= '0; hcnt <= '0; rbank <= 1'b0; eof <= 1'b0;
    end else if (restart) begin
      st <= DR_IDLE; tcol <= '0; trow <= '0; bc <= '0;
      stripe <= '0; hcnt <= '0; rbank <= 1'b0; eof <= 1'b0;
    end else begin
      case (st)
        DR_IDLE: if (full[rbank]) st <= DR_SEND;
        DR_SEND: begin
          if (tcol == TB'(TILE - 1)) begin
            tcol <= '0;
            if (trow == TB'(TILE - 1)) begin
              trow <= '0;
              hcnt <= '0;
              st   <= DR_HOLD;
            end else begin
              trow <= trow + 1'b1;
            end
          end else begin
            tcol <= tcol + 1'b1;
          end
        end
        DR_HOLD: begin
          if (hcnt == HW'(HOLD_CYC - 1)) st <= DR_GAP;
          else                           hcnt <= hcnt + 1'b1;
        end
        DR_GAP: begin
          if (last_tile_col) begin
            bc    <= '0;
            rbank <= ~rbank;
            if (stripe == SFW'(SPF - 1)) begin
              stripe <= '0;
              eof    <= 1'b1;
              st     <= DR_IDLE;
            end else begin
              stripe <= stripe + 1'b1;
              st     <= full[~rbank] ? DR_SEND : DR_IDLE;
            end
          end else begin
            bc <= bc + 1'b1;
            st <= DR_SEND;
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end

  // Burst-length window counter for the checks below.
  logic [RUNW-1:0] en_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_run <= '0;
    else if (restart) en_run <= '0;
    else if (cmp_en)  en_run <= en_run + 1'b1;
    else              en_run <= '0;
  end

  a_r6_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmp_en) && !$past(restart)) |-> (en_run == RUNW'(TILE * TILE + HOLD_CYC)));
  a_r6_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DR_GAP && !last_tile_col && !restart) |=> cmp_en);
  a_r7_eof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !restart) |=> eof);
  a_r7_eof_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !cmp_en);
endmodule

// File: rtl/raster_tile_feeder.sv
module raster_tile_feeder #(
  parameter int IMG_W    = 320,
  parameter int IMG_H    = 240,
  parameter int PIX_W    = 8,
  parameter int TILE     = 8,
  parameter int HOLD_CYC = 33,
  localparam int CW      = $clog2(IMG_W),
  localparam int RW      = $clog2(IMG_H),
  localparam int TB      = $clog2(TILE),
  localparam int BANK_SZ = TILE * IMG_W,
  localparam int DEPTH   = 2 * BANK_SZ,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_data,
  output logic               pix_ready,
  output logic [RW-1:0]      row_idx,
  output logic [CW-1:0]      col_sel,
  output logic [3*PIX_W-1:0] cmp_data,
  output logic               cmp_en,
  output logic               eof
);
  logic          wbank, cap_open;
  logic [1:0]    full;
  logic          col_max, row_max;
  logic          rbank, release_bank, send;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [PIX_W-1:0] rd_data;

  assign pix_ready = cap_open && !full[wbank];
  wire wr_we      = pix_valid && pix_ready && !frame_start;
  wire stripe_end = wr_we && col_max && (row_idx[TB-1:0] == TB'(TILE - 1));
  wire frame_end  = stripe_end && row_max;

  rtf_scan_ctr #(.MAX(IMG_W - 1), .W(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(wr_we),
    .q(col_sel), .at_max(col_max));

  rtf_scan_ctr #(.MAX(IMG_H - 1), .W(RW)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(wr_we && col_max),
    .q(row_idx), .at_max(row_max));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank <= 1'b0; cap_open <= 1'b0; full <= 2'b00;
    end else if (frame_start) begin
      wbank <= 1'b0; cap_open <= 1'b1; full <= 2'b00;
    end else begin
      if (stripe_end) begin
        full[wbank] <= 1'b1;
        wbank       <= ~wbank;
      end
      if (frame_end)    cap_open    <= 1'b0;
      if (release_bank) full[rbank] <= 1'b0;
    end
  end

  assign wr_addr = AW'((int'(wbank) * BANK_SZ)
                     + (int'(row_idx[TB-1:0]) * IMG_W) + int'(col_sel));

  rtf_stripe_store #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_we), .wr_addr(wr_addr), .wr_data(pix_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  rtf_tile_drain #(.IMG_W(IMG_W), .IMG_H(IMG_H), .TILE(TILE),
                   .HOLD_CYC(HOLD_CYC)) u_drain (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .full(full),
    .rbank(rbank), .release_bank(release_bank), .rd_addr(rd_addr),
    .send(send), .cmp_en(cmp_en), .eof(eof));

  assign cmp_data = send ? {3{rd_data}} : '0;

  // R8: capture never writes the bank the drain is reading
  a_r8_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && cmp_en) |-> (wbank != rbank));
  // R1: nothing is accepted once the frame is fully captured
  a_r1_closed_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_start) |=> !pix_ready);
endmodule

// File: tb/raster_tile_feeder_tb_top.sv
`timescale 1ns/1ps
module raster_tile_feeder_tb_top;
  localparam int W = 32, H = 24, T = 8, HOLD = 33;
  localparam int BPS = W / T, SPF = H / T, NBLK = BPS * SPF;
  localparam int BURST = T * T + HOLD;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        pix_ready, cmp_en, eof;
  logic [4:0]  row_idx;
  logic [4:0]  col_sel;
  logic [23:0] cmp_data;

  always #10 clk = ~clk;

  raster_tile_feeder #(.IMG_W(W), .IMG_H(H), .PIX_W(8), .TILE(T),
                       .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .row_idx(row_idx), .col_sel(col_sel), .cmp_data(cmp_data),
    .cmp_en(cmp_en), .eof(eof));

  int checks = 0, fails = 0;
  int fid = 0;
  bit gap_strict = 1'b0;
  int scan_bad = 0, stall_en = 0, acc_en = 0;

  function automatic logic [7:0] pix(int f, int r, int c);
    return 8'((r * 13 + c * 5 + f * 29 + (r ^ c)) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard standing in for the compressor
  int blk_done = 0, en_run = 0, low_run = 0, ord_bad = 0, rep_bad = 0;
  int ord_act = 0, ord_exp = 0;
  bit eof_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_start) begin
        blk_done = 0; en_run = 0; low_run = 0; ord_bad = 0; rep_bad = 0;
      end else begin
        if (cmp_en) begin
          if (en_run == 0 && blk_done > 0 && gap_strict)
            chk(low_run == 1, "R6", "enable drop length", low_run, 1);
          if (en_run < T * T) begin
            automatic int s = blk_done / BPS;
            automatic int b = blk_done % BPS;
            automatic int r = s * T + en_run / T;
            automatic int c = b * T + en_run % T;
            automatic logic [7:0] e = pix(fid, r, c);
            if (cmp_data[7:0] != e) begin
              if (ord_bad == 0) begin ord_act = cmp_data[7:0]; ord_exp = e; end
              ord_bad++;
            end
            if (cmp_data[15:8] != cmp_data[7:0] || cmp_data[23:16] != cmp_data[7:0])
              rep_bad++;
          end else if (cmp_data != '0) begin
            rep_bad++;
          end
          en_run++;
        end else begin
          if (en_run > 0) begin
            chk(en_run == BURST, "R6", "enable burst length", en_run, BURST);
            chk(ord_bad == 0, "R5", "tile pixel order", ord_act, ord_exp);
            chk(rep_bad == 0, "R4", "byte lane copies", rep_bad, 0);
            blk_done++; en_run = 0; low_run = 0; ord_bad = 0; rep_bad = 0;
          end
          low_run++;
        end
        if (eof && !eof_prev)
          chk(blk_done == NBLK, "R7", "tiles before eof", blk_done, NBLK);
      end
      eof_prev = eof;
    end
  end

  task automatic pulse_start(int f);
    fid = f;
    @(posedge clk); #2 frame_start = 1'b1;
    @(posedge clk); #2 frame_start = 1'b0;
  endtask

  task automatic stream(int f, int npix, int spacing);
    int n = 0;
    scan_bad = 0; stall_en = 0; acc_en = 0;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        bit acc;
        if (n >= npix) return;
        pix_valid = 1'b1; pix_data = pix(f, r, c);
        if (int'(col_sel) != c || int'(row_idx) != r) scan_bad++;
        do begin
          acc = pix_ready;
          if (!acc && cmp_en) stall_en++;
          if (acc && cmp_en)  acc_en++;
          @(posedge clk); #2;
        end while (!acc);
        pix_valid = 1'b0;
        n++;
        for (int k = 0; k < spacing; k++) begin @(posedge clk); #2; end
      end
    end
  endtask

  task automatic wait_eof();
    int n = 0;
    while (!eof && n < 20000) begin @(posedge clk); #2; n++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(pix_ready == 1'b0, "R9", "ready in reset", pix_ready, 0);
    chk(cmp_en == 1'b0 && eof == 1'b0, "R9", "enable/eof in reset", {cmp_en, eof}, 0);
    chk(row_idx == 0 && col_sel == 0 && cmp_data == 0, "R9", "counters/data in reset",
        int'(row_idx) + int'(col_sel), 0);
    rst_n = 1'b1;
    pix_valid = 1'b1; pix_data = 8'hA5;
    repeat (5) begin @(posedge clk); #2; end
    chk(col_sel == 0 && pix_ready == 1'b0, "R1", "pixel ignored before frame_start",
        int'(col_sel), 0);
    pix_valid = 1'b0;
  endtask

  task automatic t_burst_frame(int f);
    gap_strict = 1'b1;
    pulse_start(f);
    chk(row_idx == 0 && col_sel == 0 && eof == 0, "R3", "state after start",
        int'(row_idx) + int'(col_sel) + int'(eof), 0);
    stream(f, W * H, 0);
    chk(scan_bad == 0, "R2", "scan counters track pixels", scan_bad, 0);
    chk(row_idx == 0 && col_sel == 0, "R2", "row and column wrap at frame end",
        int'(row_idx) * 100 + int'(col_sel), 0);
    chk(stall_en > 0, "R8", "capture stalls with both banks full", stall_en, 1);
    chk(acc_en > 0, "R8", "capture overlaps drain", acc_en, 1);
    chk(pix_ready == 1'b0, "R1", "ready low after last pixel", pix_ready, 0);
    wait_eof();
    chk(eof == 1'b1, "R7", "eof raised", eof, 1);
    pix_valid = 1'b1; pix_data = 8'h5A;
    repeat (40) begin @(posedge clk); #2; end
    chk(eof == 1'b1 && cmp_en == 1'b0, "R7", "eof sticky and quiet", {eof, cmp_en}, 2);
    chk(col_sel == 0 && row_idx == 0, "R1", "extra pixel ignored", int'(col_sel), 0);
    pix_valid = 1'b0;
    gap_strict = 1'b0;
  endtask

  task automatic t_sparse_frame(int f);
    gap_strict = 1'b0;
    pulse_start(f);
    chk(eof == 1'b0, "R3", "eof cleared by start", eof, 0);
    stream(f, W * H, 5);
    chk(scan_bad == 0, "R2", "scan counters with idle gaps", scan_bad, 0);
    chk(stall_en == 0, "R8", "no stall when drain keeps up", stall_en, 0);
    wait_eof();
    chk(eof == 1'b1, "R7", "eof after sparse frame", eof, 1);
  endtask

  task automatic t_restart(int f);
    gap_strict = 1'b0;
    pulse_start(f);
    stream(f, 2 * T * W + 20, 0);
    repeat (30) begin @(posedge clk); #2; end
    pulse_start(f + 1);
    chk(row_idx == 0 && col_sel == 0, "R3", "counters zero after mid-frame start",
        int'(row_idx) * 100 + int'(col_sel), 0);
    chk(cmp_en == 1'b0 && eof == 1'b0, "R3", "drain stopped by start", {cmp_en, eof}, 0);
    chk(pix_ready == 1'b1, "R3", "capture rearmed", pix_ready, 1);
    gap_strict = 1'b1;
    stream(f + 1, W * H, 0);
    wait_eof();
    chk(eof == 1'b1, "R3", "frame after restart completes", eof, 1);
    gap_strict = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_burst_frame(1);
    t_sparse_frame(2);
    t_restart(3);
    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule